// File: doc/BRIEF.md
# ADC scan control sequencer

This block is the digital control side of a multi-channel analog-to-digital converter. Software programs a byte-wide control register and a scan-range register over a simple register bus. Once its run bit is set, the block converts channel 0 up to a chosen last channel, one channel at a time. For each conversion it sends a one-cycle start pulse to the converter core. It then waits for the core's done pulse and stores the 10-bit result in that channel's data register, which the bus can read.

The block has two scan modes. A one-pass scan stops by itself: the run bit drops after the last channel's result has been stored. A repeating scan wraps back to channel 0 and keeps going until software clears the run bit or the stop input is raised. Every finished pass sets an end-of-scan flag, and the interrupt line is high while that flag and the interrupt enable are both set. An optional auto-clear mode zeroes a data register once it has been read, so software can tell a stale result from a fresh one.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `conv_start` is 0.
- R2: The control register is at address 0. Bit 7 is run, bit 6 is repeat mode, bit 5 is auto-clear, bit 4 is the interrupt enable, bit 1 is the trigger enable and bit 0 is the trigger select. Bits 3:2 always read 0 whatever is written to them, and the other bits read back what was written.
- R3: While run is 0, no start pulse is issued.
- R4: In one-pass mode (bit 6 = 0), writing run = 1 converts channels 0 up to the last channel in ascending order. Each result goes to the data register of its channel. The register for channel n is at address 4+n, with the result in bits 9:0. Run reads 0 once the last result is stored.
- R5: In repeat mode (bit 6 = 1), passes over channel 0 up to the last channel repeat back to back, and run stays 1.
- R6: A one-cycle pulse on `stop` clears run. The sequencer then goes idle and issues no further start pulses.
- R7: A control write made while run is 1 leaves the repeat-mode bit unchanged, but the run bit in that same write is applied.
- R8: With auto-clear on, a data register reads 0x0000 from the cycle after a bus read of it. With auto-clear off, reads do not change it.
- R9: The scan register is at address 1. Bits 1:0 hold the last channel index, and bit 7 is the end-of-scan flag. The flag is set at the end of every pass, and writing 1 to bit 7 clears it. `irq` equals the flag ANDed with the interrupt enable.
- R10: If run is cleared while a conversion is in flight, the late result is discarded, the data register keeps its old value, and the sequencer goes idle.
- R11: Each start pulse lasts exactly one cycle, and `conv_ch` carries the channel number being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop | input | 1 | Standby request; clears run |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; drives auto-clear |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | End-of-scan interrupt |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | 2 | Channel being converted |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 10 | Result, valid with `conv_done` |

## Verification
The checks assume the following about the block's inputs:
- The converter answers each start pulse with exactly one done pulse.
- Software never sets run in the same cycle that a one-pass scan ends.
- Read and write strobes are each a single cycle.

The converter stub in the bench answers every start pulse with a single done pulse three cycles later. The bench waits for run to read 0, and for any pending done pulse to drain, before it starts another scan. An abandoned conversion's late done pulse therefore arrives only while the sequencer is idle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // control register bit positions
    localparam int CB_RUN   = 7;
    localparam int CB_REP   = 6;
    localparam int CB_ACLR  = 5;
    localparam int CB_IE    = 4;
    localparam int CB_TRGEN = 1;
    localparam int CB_TRGSL = 0;
    // scan register flag position
    localparam int SB_FLAG  = 7;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int CH_W   = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              scan_end,
    input  logic              clr_run,
    output logic              run,
    output logic              rep,
    output logic              aclr,
    output logic [CH_W-1:0]   last_ch,
    output logic              eos,
    output logic [7:0]        ctrl_byte,
    output logic [7:0]        scan_byte,
    output logic              irq
);

    typedef struct packed {
        logic            run;
        logic            rep;
        logic            aclr;
        logic            ie;
        logic            trg_en;
        logic            trg_sel;
        logic [CH_W-1:0] last;
        logic            eos;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_scan;
    logic  unused_bits;

    assign wr_ctrl     = bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_scan     = bus_wr && (bus_addr == ADDR_W'(1));
    assign unused_bits = ^bus_wdata[3:2];

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.run     = bus_wdata[CB_RUN];
            if (!r_q.run) r_d.rep = bus_wdata[CB_REP];
            r_d.aclr    = bus_wdata[CB_ACLR];
            r_d.ie      = bus_wdata[CB_IE];
            r_d.trg_en  = bus_wdata[CB_TRGEN];
            r_d.trg_sel = bus_wdata[CB_TRGSL];
        end
        if (wr_scan) begin
            r_d.last = bus_wdata[CH_W-1:0];
            if (bus_wdata[SB_FLAG]) r_d.eos = 1'b0;
        end
        if (scan_end) r_d.eos = 1'b1;
        if (clr_run)  r_d.run = 1'b0;
        if (stop)     r_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run       = r_q.run;
    assign rep       = r_q.rep;
    assign aclr      = r_q.aclr;
    assign last_ch   = r_q.last;
    assign eos       = r_q.eos;
    assign irq       = r_q.eos & r_q.ie;
    assign ctrl_byte = {r_q.run, r_q.rep, r_q.aclr, r_q.ie, 2'b00, r_q.trg_en, r_q.trg_sel};
    assign scan_byte = {r_q.eos, {(7-CH_W){1'b0}}, r_q.last};

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            rep,
    input  logic [CH_W-1:0] last_ch,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] cur_ch,
    output logic            cap_en,
    output logic            scan_end,
    output logic            clr_run
);

    typedef struct packed {
        seq_state_e      st;
        logic [CH_W-1:0] ch;
    } fsm_t;

    fsm_t f_d, f_q;
    logic at_last;

    assign at_last = (f_q.ch >= last_ch) || (f_q.ch == CH_W'(NUM_CH-1));

    always_comb begin
        f_d      = f_q;
        cap_en   = 1'b0;
        scan_end = 1'b0;
        clr_run  = 1'b0;
        case (f_q.st)
            SEQ_IDLE: begin
                if (run) begin
                    f_d.st = SEQ_ISSUE;
                    f_d.ch = '0;
                end
            end
            SEQ_ISSUE: f_d.st = run ? SEQ_WAIT : SEQ_IDLE;
            SEQ_WAIT: begin
                if (!run) begin
                    f_d.st = SEQ_IDLE;
                end else if (conv_done) begin
                    cap_en = 1'b1;
                    if (at_last) begin
                        scan_end = 1'b1;
                        f_d.ch   = '0;
                        if (rep) begin
                            f_d.st = SEQ_ISSUE;
                        end else begin
                            clr_run = 1'b1;
                            f_d.st  = SEQ_IDLE;
                        end
                    end else begin
                        f_d.ch = f_q.ch + 1'b1;
                        f_d.st = SEQ_ISSUE;
                    end
                end
            end
            default: f_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: SEQ_IDLE, ch: '0};
        else        f_q <= f_d;
    end

    assign conv_start = (f_q.st == SEQ_ISSUE) && run;
    assign cur_ch     = f_q.ch;

endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 3,
    parameter int RES_W  = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          aclr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          cap_en,
    input  logic [CH_W-1:0]               cap_ch,
    input  logic [RES_W-1:0]              cap_data,
    output logic [NUM_CH-1:0][RES_W-1:0]  data
);

    logic [RES_W-1:0] data_d [NUM_CH];
    logic [RES_W-1:0] data_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic rd_hit;
        assign rd_hit = bus_rd && bus_addr[ADDR_W-1] && (bus_addr[CH_W-1:0] == CH_W'(i));

        always_comb begin
            data_d[i] = data_q[i];
            if (aclr && rd_hit)                 data_d[i] = '0;
            if (cap_en && cap_ch == CH_W'(i))   data_d[i] = cap_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) data_q[i] <= '0;
            else        data_q[i] <= data_d[i];
        end

        assign data[i] = data_q[i];
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int RES_W  = 10,
    parameter  int DATA_W = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result
);

    logic                         run, rep, aclr, eos;
    logic                         cap_en, scan_end, clr_run;
    logic [CH_W-1:0]              last_ch, cur_ch;
    logic [7:0]                   ctrl_byte, scan_byte;
    logic [NUM_CH-1:0][RES_W-1:0] data;

    adc_scan_regs #(.CH_W(CH_W), .ADDR_W(ADDR_W)) u_regs (
        .clk, .rst_n, .stop, .bus_wr, .bus_addr, .bus_wdata,
        .scan_end, .clr_run, .run, .rep, .aclr, .last_ch, .eos,
        .ctrl_byte, .scan_byte, .irq
    );

    adc_scan_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
        .clk, .rst_n, .run, .rep, .last_ch, .conv_done,
        .conv_start, .cur_ch, .cap_en, .scan_end, .clr_run
    );

    adc_scan_results #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .RES_W(RES_W)) u_res (
        .clk, .rst_n, .aclr, .bus_rd, .bus_addr,
        .cap_en, .cap_ch(cur_ch), .cap_data(conv_result), .data
    );

    assign conv_ch = cur_ch;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            if (bus_addr[CH_W-1:0] <= CH_W'(NUM_CH-1))
                bus_rdata = DATA_W'(data[bus_addr[CH_W-1:0]]);
        end else if (bus_addr == ADDR_W'(0)) begin
            bus_rdata = DATA_W'(ctrl_byte);
        end else if (bus_addr == ADDR_W'(1)) begin
            bus_rdata = DATA_W'(scan_byte);
        end
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              rep,
    input logic              eos,
    input logic              conv_start,
    input logic              cap_en,
    input logic              scan_end,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |-> (bus_rdata[3:2] == 2'b00));

    assert_no_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !conv_start);

    assert_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_end && !rep) |=> !run);

    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bus_wr && bus_addr == ADDR_W'(0)) |=> $stable(rep));

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end |=> eos);

    assert_no_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cap_en);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .rep(rep), .eos(eos),
    .conv_start(conv_start), .cap_en(cap_en), .scan_end(scan_end),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, conv_start;
    logic [1:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_result = '0;

    int total = 0;
    int bad = 0;
    int starts = 0;
    int seq_err = 0;
    int wide_err = 0;
    int serial = 0;
    logic [1:0] scan_last = '0;
    logic [1:0] exp_next = '0;
    logic [9:0] exp_data [4];

    // {last channel[1:0], interrupt enable, auto-clear}
    localparam logic [3:0] VEC [6] = '{4'b00_0_0, 4'b01_1_0, 4'b10_0_1,
                                       4'b11_1_1, 4'b11_0_0, 4'b00_1_1};

    always #2 clk = ~clk;

    adc_scan_seq u_dut (
        .clk, .rst_n, .stop, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
        .bus_rdata, .irq, .conv_start, .conv_ch, .conv_done, .conv_result
    );

    // converter stub: done three cycles after the start pulse is seen
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_start) begin
                logic [1:0] ch;
                ch = conv_ch;
                starts++;
                if (ch != exp_next) seq_err++;
                exp_next = (ch == scan_last) ? 2'd0 : ch + 2'd1;
                repeat (2) @(negedge clk);
                serial++;
                conv_result = {serial[7:0], ch};
                exp_data[ch] = conv_result;
                conv_done = 1'b1;
            end
        end
    end

    // start pulse width monitor (R11)
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (conv_start && prev) wide_err++;
            prev = conv_start;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle;
        logic [15:0] d;
        for (int k = 0; k < 200; k++) begin
            bus_read(3'd0, d);
            if (!d[7]) break;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d, d2;
        int s0;
        logic [9:0] keep;
        for (int i = 0; i < 4; i++) exp_data[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd0, d); chk(d == 16'h0, "R1 ctrl", d, 16'h0);
        bus_read(3'd1, d); chk(d == 16'h0, "R1 scan", d, 16'h0);
        for (int c = 0; c < 4; c++) begin
            bus_read(3'(4 + c), d); chk(d == 16'h0, "R1 data", d, 16'h0);
        end
        chk(irq == 1'b0, "R1 irq", 16'(irq), 16'h0);
        chk(conv_start == 1'b0, "R1 conv_start", 16'(conv_start), 16'h0);

        // R2 reserved bits, R3 no start while run is 0
        bus_write(3'd0, 8'h7F);
        bus_read(3'd0, d); chk(d == 16'h0073, "R2 readback", d, 16'h0073);
        repeat (20) @(negedge clk);
        chk(starts == 0, "R3 no start", 16'(starts), 16'h0);
        bus_write(3'd0, 8'h00);

        // table of one-pass scans: R4, R8, R9, R11
        foreach (VEC[v]) begin
            logic [1:0] last;
            logic ie, ac;
            last = VEC[v][3:2]; ie = VEC[v][1]; ac = VEC[v][0];
            scan_last = last; exp_next = 2'd0;
            bus_write(3'd1, {1'b1, 5'b0, last});
            s0 = starts;
            bus_write(3'd0, {1'b1, 1'b0, ac, ie, 4'b0});
            wait_idle();
            bus_read(3'd0, d);
            chk(d[7] == 1'b0, "R4 run cleared", d, {8'h0, 1'b0, 1'b0, ac, ie, 4'b0});
            chk(starts - s0 == int'(last) + 1, "R4 conversions", 16'(starts - s0), 16'(int'(last) + 1));
            bus_read(3'd1, d);
            chk(d[7] == 1'b1, "R9 flag set", d, {8'h0, 1'b1, 5'b0, last});
            chk(irq == ie, "R9 irq", 16'(irq), 16'(ie));
            for (int c = 0; c <= int'(last); c++) begin
                bus_read(3'(4 + c), d);
                chk(d == 16'(exp_data[c]), "R4 result", d, 16'(exp_data[c]));
                bus_read(3'(4 + c), d2);
                chk(d2 == (ac ? 16'h0 : 16'(exp_data[c])), "R8 after read", d2,
                    ac ? 16'h0 : 16'(exp_data[c]));
            end
            chk(seq_err == 0, "R11 channel order", 16'(seq_err), 16'h0);
            chk(wide_err == 0, "R11 pulse width", 16'(wide_err), 16'h0);
        end

        // R9 write-one-to-clear
        bus_write(3'd0, 8'h10);
        bus_write(3'd1, 8'h81);
        bus_read(3'd1, d); chk(d[7] == 1'b0, "R9 flag cleared", d, 16'h0001);
        chk(irq == 1'b0, "R9 irq low", 16'(irq), 16'h0);

        // R5 repeating scan over channels 0..1
        scan_last = 2'd1; exp_next = 2'd0;
        s0 = starts;
        bus_write(3'd0, 8'hC0);
        repeat (40) @(negedge clk);
        bus_read(3'd0, d); chk(d == 16'h00C0, "R5 run held", d, 16'h00C0);
        chk(starts - s0 >= 8, "R5 repeats", 16'(starts - s0), 16'd8);
        bus_read(3'd1, d); chk(d[7] == 1'b1, "R5 pass flag", d, 16'h0081);
        chk(seq_err == 0, "R5 order", 16'(seq_err), 16'h0);

        // R6 stop input
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (8) @(negedge clk);
        s0 = starts;
        repeat (20) @(negedge clk);
        chk(starts == s0, "R6 no starts", 16'(starts - s0), 16'h0);
        bus_read(3'd0, d); chk(d == 16'h0040, "R6 run cleared", d, 16'h0040);
        bus_write(3'd0, 8'h00);

        // R7 mode bit locked while running
        scan_last = 2'd3; exp_next = 2'd0;
        bus_write(3'd1, 8'h83);
        bus_write(3'd0, 8'h80);
        bus_write(3'd0, 8'hC0);
        bus_read(3'd0, d); chk(d == 16'h0080, "R7 mode ignored", d, 16'h0080);
        wait_idle();
        bus_read(3'd0, d); chk(d == 16'h0000, "R7 stays one-pass", d, 16'h0000);
        repeat (6) @(negedge clk);
        exp_next = 2'd0;
        bus_write(3'd0, 8'h80);
        bus_write(3'd0, 8'h40);
        bus_read(3'd0, d); chk(d == 16'h0000, "R7 run honoured", d, 16'h0000);
        repeat (10) @(negedge clk);

        // R10 abandoned conversion
        bus_read(3'd4, d);
        keep = d[9:0];
        exp_next = 2'd0;
        s0 = starts;
        bus_write(3'd0, 8'h80);
        bus_write(3'd0, 8'h00);
        repeat (10) @(negedge clk);
        bus_read(3'd4, d); chk(d == 16'(keep), "R10 result dropped", d, 16'(keep));
        chk(starts - s0 == 1, "R10 idle", 16'(starts - s0), 16'h1);
        bus_read(3'd0, d); chk(d == 16'h0000, "R10 run low", d, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule